// File: doc/BRIEF.md
# Instruction Doorbell Counter and Fetcher

This block keeps the per-queue account of instruction words that software has posted, and turns that account into fetch requests for fixed-size instructions held in a linear buffer. Software announces new work by writing a word count to the doorbell input. The block adds that value to a 20-bit pending count. While the queue is enabled and at least one whole instruction (8 words of 64 bits, 64 bytes) is pending, it raises a fetch request carrying a 64-byte-aligned address. Each accepted request removes 8 words from the count and moves the address on by 64 bytes.

The pending count is 20 bits wide and wraps when an addition exceeds it. A wrap sets a sticky overflow status flag. Software clears that flag by writing one to its clear input, and it gates the resulting interrupt with an enable bit that has separate set and clear inputs. Software can return the count to zero on purpose by writing 2^20 minus the current count, which wraps the count to exactly zero. The starting address is loaded through a write port, and the next-fetch pointer can be read back at any time.

Top module: `qdb_fetch`

## Requirements
- R1: After a synchronous reset the pending count, the fetch pointer, the overflow flag, the interrupt enable and the interrupt are all zero, and no fetch is requested.
- R2: A doorbell write adds `db_val` to the pending count. The new count is visible on `pend_cnt` one clock after the write.
- R3: `fetch_req` is high in a cycle exactly when `q_en` was high in the previous cycle and `pend_cnt` is at least 8. `fetch_addr` equals `next_ptr` shifted left by 6, so bits 5:0 are zero.
- R4: A cycle with `fetch_req` and `fetch_ack` both high lowers the count by 8 and raises `next_ptr` by one (64 bytes). `fetch_ack` while `fetch_req` is low changes neither the count nor the pointer.
- R5: A doorbell write and an accepted fetch in the same cycle produce one update: the new count is count + `db_val` - 8.
- R6: When count + `db_val` carries out of 20 bits, the count keeps the low 20 bits and the overflow flag is set. The flag appears as bit 1 of the 7-bit `irq_vec`, and all other bits of `irq_vec` are zero.
- R7: The overflow flag stays set until `ovf_clr` is pulsed. If a new overflow arrives in the same cycle as `ovf_clr`, the flag stays set.
- R8: Writing 2^20 minus the current count to the doorbell leaves the count at zero and sets the overflow flag.
- R9: `ovf_ena_set` sets and `ovf_ena_clr` clears the interrupt enable, with set taking priority. `irq` is high exactly when the overflow flag and the enable are both set.
- R10: While `q_en` is low, no new fetch is requested and the pending count is kept unchanged.
- R11: `base_wr` loads `base_ptr` (address bits 48:6) into the fetch pointer. If it coincides with an accepted fetch, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_val | input | 20 | Word count to add |
| q_en | input | 1 | Queue enable |
| base_wr | input | 1 | Start-pointer write strobe |
| base_ptr | input | 43 | Start address bits 48:6 |
| fetch_ack | input | 1 | Fetch request accepted |
| ovf_clr | input | 1 | Write-one-to-clear of the overflow flag |
| ovf_ena_set | input | 1 | Set the overflow interrupt enable |
| ovf_ena_clr | input | 1 | Clear the overflow interrupt enable |
| fetch_req | output | 1 | Fetch request |
| fetch_addr | output | 49 | 64-byte-aligned fetch address |
| pend_cnt | output | 20 | Pending doorbell word count |
| next_ptr | output | 43 | Next fetch pointer (address bits 48:6) |
| irq_vec | output | 7 | Miscellaneous status vector, overflow in bit 1 |
| ovf_ena | output | 1 | Overflow interrupt enable |
| irq | output | 1 | Overflow interrupt |

## Verification
The count takes two updates that can land in the same clock: a doorbell addition and the 8-word subtraction of an accepted fetch. The same holds for the pointer, where a base load can meet a fetch step. The bench provokes both by driving `db_wr` or `base_wr` in the very cycle it holds `fetch_ack` against a standing request. It expects a single combined count (count + value - 8) and the loaded pointer, not the stepped one. The overflow flag is also set and cleared in one cycle, and there the bench expects the set to win.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  // words of 64 bits per instruction
  localparam int INST_WORDS = 8;
  // width of the miscellaneous status vector and the overflow position in it
  localparam int IVEC_W  = 7;
  localparam int OVF_POS = 1;
endpackage

// File: rtl/qdb_counter.sv
module qdb_counter #(
  parameter int CNT_W = 20,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             take,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [CNT_W:0] sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + {1'b0, (add_en ? add_val : '0)};
    wrap  = sum[CNT_W];
    cnt_d = sum[CNT_W-1:0] - (take ? STEP_V : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qdb_ptr.sv
module qdb_ptr #(
  parameter int PTR_W = 43
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (load) ptr_q <= load_val;
    else if (step) ptr_q <= ptr_q + PTR_W'(1);
  end
endmodule

// File: rtl/qdb_flag.sv
module qdb_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic w1c,
  input  logic ena_set,
  input  logic ena_clr,
  output logic flag_q,
  output logic ena_q,
  output logic irq_q
);
  logic flag_d, ena_d;

  always_comb begin
    flag_d = set_evt | (flag_q & ~w1c);
    ena_d  = ena_set | (ena_q & ~ena_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ena_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ena_q  <= ena_d;
      irq_q  <= flag_d & ena_d;
    end
  end
endmodule

// File: rtl/qdb_fetch.sv
module qdb_fetch
  import qdb_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int AW    = 49,
  parameter int ALIGN = 6,
  localparam int PTR_W = AW - ALIGN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              db_wr,
  input  logic [CNT_W-1:0]  db_val,
  input  logic              q_en,
  input  logic              base_wr,
  input  logic [PTR_W-1:0]  base_ptr,
  input  logic              fetch_ack,
  input  logic              ovf_clr,
  input  logic              ovf_ena_set,
  input  logic              ovf_ena_clr,
  output logic              fetch_req,
  output logic [AW-1:0]     fetch_addr,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic [PTR_W-1:0]  next_ptr,
  output logic [IVEC_W-1:0] irq_vec,
  output logic              ovf_ena,
  output logic              irq
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(INST_WORDS);

  logic             take;
  logic             wrap;
  logic             flag;
  logic [CNT_W-1:0] cnt_d;
  logic             req_q;

  assign take = req_q & fetch_ack;

  qdb_counter #(.CNT_W(CNT_W), .STEP(INST_WORDS)) u_cnt (
    .clk(clk), .rst(rst), .add_en(db_wr), .add_val(db_val), .take(take),
    .cnt_q(pend_cnt), .cnt_d(cnt_d), .wrap(wrap)
  );

  qdb_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(base_wr), .load_val(base_ptr), .step(take),
    .ptr_q(next_ptr)
  );

  qdb_flag u_flag (
    .clk(clk), .rst(rst), .set_evt(wrap), .w1c(ovf_clr),
    .ena_set(ovf_ena_set), .ena_clr(ovf_ena_clr),
    .flag_q(flag), .ena_q(ovf_ena), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= q_en & (cnt_d >= STEP_V);
  end

  assign fetch_req  = req_q;
  assign fetch_addr = {next_ptr, {ALIGN{1'b0}}};

  always_comb begin
    irq_vec          = '0;
    irq_vec[OVF_POS] = flag;
  end
endmodule

// File: rtl/qdb_fetch_chk.sv
module qdb_fetch_chk #(
  parameter int CNT_W = 20,
  parameter int PTR_W = 43
) (
  input logic             clk,
  input logic             rst,
  input logic             db_wr,
  input logic [CNT_W-1:0] db_val,
  input logic             q_en,
  input logic             base_wr,
  input logic             fetch_ack,
  input logic             ovf_clr,
  input logic             fetch_req,
  input logic [CNT_W-1:0] pend_cnt,
  input logic [PTR_W-1:0] next_ptr,
  input logic [6:0]       irq_vec
);
  AST_DB_ADD: assert property (@(posedge clk) disable iff (rst)
    (db_wr && !(fetch_req && fetch_ack)) |=> pend_cnt == CNT_W'($past(pend_cnt) + $past(db_val))); // R2
  AST_REQ_HAS_WORDS: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> pend_cnt >= CNT_W'(8)); // R3
  AST_FETCH_DEC: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_ack && !db_wr) |=> pend_cnt == CNT_W'($past(pend_cnt) - CNT_W'(8))); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_ack && !base_wr) |=> next_ptr == PTR_W'($past(next_ptr) + PTR_W'(1))); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_vec[1] && !ovf_clr) |=> irq_vec[1]); // R7
  AST_EN_STOP: assert property (@(posedge clk) disable iff (rst)
    !q_en |=> !fetch_req); // R10
endmodule

bind qdb_fetch qdb_fetch_chk #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .db_wr(db_wr), .db_val(db_val), .q_en(q_en),
  .base_wr(base_wr), .fetch_ack(fetch_ack), .ovf_clr(ovf_clr),
  .fetch_req(fetch_req), .pend_cnt(pend_cnt), .next_ptr(next_ptr),
  .irq_vec(irq_vec)
);

// File: tb/tb_qdb_fetch.sv
module tb_qdb_fetch;
  logic        clk = 1'b0;
  logic        rst;
  logic        db_wr, q_en, base_wr, fetch_ack, ovf_clr, ovf_ena_set, ovf_ena_clr;
  logic [19:0] db_val;
  logic [42:0] base_ptr;
  logic        fetch_req, ovf_ena, irq;
  logic [48:0] fetch_addr;
  logic [19:0] pend_cnt;
  logic [42:0] next_ptr;
  logic [6:0]  irq_vec;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  qdb_fetch dut (
    .clk(clk), .rst(rst), .db_wr(db_wr), .db_val(db_val), .q_en(q_en),
    .base_wr(base_wr), .base_ptr(base_ptr), .fetch_ack(fetch_ack),
    .ovf_clr(ovf_clr), .ovf_ena_set(ovf_ena_set), .ovf_ena_clr(ovf_ena_clr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .pend_cnt(pend_cnt),
    .next_ptr(next_ptr), .irq_vec(irq_vec), .ovf_ena(ovf_ena), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    db_wr = 0; db_val = '0; base_wr = 0; base_ptr = '0; fetch_ack = 0;
    ovf_clr = 0; ovf_ena_set = 0; ovf_ena_clr = 0;
  endtask

  task automatic do_reset();
    idle(); q_en = 0; rst = 1;
    tick(); tick();
    rst = 0;
  endtask

  task automatic doorbell(input logic [19:0] v);
    db_wr = 1; db_val = v; tick(); db_wr = 0; db_val = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt", 64'(pend_cnt), 0);
    chk("R1 req", 64'(fetch_req), 0);
    chk("R1 ptr", 64'(next_ptr), 0);
    chk("R1 vec", 64'(irq_vec), 0);
    chk("R1 ena", 64'(ovf_ena), 0);
    chk("R1 irq", 64'(irq), 0);
  endtask

  task automatic t_doorbell();
    do_reset();
    doorbell(20'd16);
    chk("R2 first add", 64'(pend_cnt), 16);
    doorbell(20'd8);
    chk("R2 second add", 64'(pend_cnt), 24);
    chk("R10 no req while disabled", 64'(fetch_req), 0);
  endtask

  task automatic t_fetch();
    do_reset();
    base_wr = 1; base_ptr = 43'h100; tick(); base_wr = 0;
    chk("R11 base load", 64'(next_ptr), 64'h100);
    doorbell(20'd24);
    q_en = 1; tick();
    chk("R3 req on", 64'(fetch_req), 1);
    chk("R3 addr", 64'(fetch_addr), 64'h4000);
    fetch_ack = 1; tick();
    chk("R4 cnt", 64'(pend_cnt), 16);
    chk("R4 ptr", 64'(next_ptr), 64'h101);
    tick();
    chk("R4 cnt 8", 64'(pend_cnt), 8);
    chk("R3 req at 8", 64'(fetch_req), 1);
    tick(); fetch_ack = 0;
    chk("R4 cnt 0", 64'(pend_cnt), 0);
    chk("R3 req off below 8", 64'(fetch_req), 0);
    chk("R4 ptr 3 steps", 64'(next_ptr), 64'h103);
    fetch_ack = 1; tick(); fetch_ack = 0;
    chk("R4 stray ack cnt", 64'(pend_cnt), 0);
    chk("R4 stray ack ptr", 64'(next_ptr), 64'h103);
  endtask

  task automatic t_simul();
    do_reset();
    q_en = 1;
    doorbell(20'd16);
    chk("R3 req", 64'(fetch_req), 1);
    db_wr = 1; db_val = 20'd24; fetch_ack = 1; tick();
    idle();
    chk("R5 combined", 64'(pend_cnt), 32);
    base_wr = 1; base_ptr = 43'h5; fetch_ack = 1; tick();
    idle();
    chk("R11 load beats step", 64'(next_ptr), 64'h5);
    chk("R5 cnt after", 64'(pend_cnt), 24);
  endtask

  task automatic t_disable();
    do_reset();
    q_en = 1;
    doorbell(20'd32);
    chk("R3 req", 64'(fetch_req), 1);
    q_en = 0; tick();
    chk("R10 req off", 64'(fetch_req), 0);
    fetch_ack = 1; tick(); tick(); fetch_ack = 0;
    chk("R10 cnt kept", 64'(pend_cnt), 32);
    chk("R10 req still off", 64'(fetch_req), 0);
  endtask

  task automatic t_overflow();
    do_reset();
    doorbell(20'd32);
    doorbell(20'hFFFF8);
    chk("R6 wrapped cnt", 64'(pend_cnt), 24);
    chk("R6 vec", 64'(irq_vec), 64'h2);
    chk("R9 irq gated", 64'(irq), 0);
    ovf_ena_set = 1; tick(); ovf_ena_set = 0;
    chk("R9 ena", 64'(ovf_ena), 1);
    chk("R9 irq on", 64'(irq), 1);
    tick();
    chk("R7 sticky", 64'(irq_vec), 64'h2);
    ovf_clr = 1; tick(); ovf_clr = 0;
    chk("R7 cleared", 64'(irq_vec), 0);
    chk("R9 irq off", 64'(irq), 0);
    db_wr = 1; db_val = 20'hFFFE8; ovf_clr = 1; tick(); idle();
    chk("R8 cleared count", 64'(pend_cnt), 0);
    chk("R7 set wins", 64'(irq_vec), 64'h2);
    ovf_ena_set = 1; ovf_ena_clr = 1; tick(); idle();
    chk("R9 set priority", 64'(ovf_ena), 1);
    ovf_ena_clr = 1; tick(); idle();
    chk("R9 ena clr", 64'(ovf_ena), 0);
    chk("R9 irq clr", 64'(irq), 0);
  endtask

  initial begin
    idle(); q_en = 0; rst = 1;
    t_reset();
    t_doorbell();
    t_fetch();
    t_simul();
    t_disable();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule